// File: doc/BRIEF.md
# Peripheral Bus Phase Sequencer

This block walks an 8-bit parallel peripheral bus through its protocol phases on behalf of the devices attached to it. It starts with the bus idle. When devices ask for the bus, it runs a fixed-length arbitration window and resolves it by device ID, with the higher ID winning. It then passes through selection and the command bytes, moves data bytes in either direction, and collects a status byte. Message bytes decide whether the connection ends for good or is parked. Every phase change is made on a clock edge, and the current phase is always visible on an output.

A target can park a transfer in the middle of the data phase with a disconnect message. The sequencer stores that connection's context (initiator, target, direction, length and byte count) and frees the bus. When the parked target later wins arbitration, the sequencer takes the reselection path, restores that context and resumes the data phase at the stored count. Save-pointer and restore-pointer messages let the current byte count be marked and rewound while a connection is open.

Top module: `sbp_phase_seq`

## Requirements
- R1: After reset, phase is bus-free (code 0), byte_count is 0 and resume_pending is 0.
- R2: In bus-free (0), any set bit of arb_req moves the phase to arbitration (code 1) on the next edge. With arb_req all zero the phase stays bus-free.
- R3: Arbitration lasts exactly ARB_CYCLES cycles. The winner is the highest-numbered set bit of arb_req in the last arbitration cycle. If no bit is set then, the phase returns to bus-free.
- R4: A normal win gives selection (code 2) for one cycle, then command (code 4). owner_id is the winner. target_id, data_in and the transfer length are taken from sel_target, xfer_dir and xfer_len at the end of arbitration.
- R5: In command, CMD_LEN cmd_valid strobes move the phase to data (code 5) with byte_count 0. bus_byte shows the last accepted byte. data_valid has no effect in command.
- R6: In data, each data_valid adds one to byte_count. When byte_count reaches the length, the phase moves to status (code 6). A zero length goes to status one cycle after entering data.
- R7: If data_valid and msg_req arrive together in data, the byte is counted first. If that byte completes the transfer, the phase goes to status. Otherwise it goes to message (code 7) holding the incremented count.
- R8: In status, status_valid moves the phase to message, and the status byte appears on bus_byte.
- R9: In message, byte 0x00 (command complete) returns the phase to bus-free. A byte with bit 7 set (identify) leaves phase and count unchanged.
- R10: In message, byte 0x04 (disconnect) returns the phase to bus-free, stores the connection context and sets resume_pending.
- R11: While resume_pending is set, a win by the stored target gives reselection (code 3) with owner_id set to the stored initiator. On the next edge the phase becomes data with byte_count restored, and resume_pending clears.
- R12: In message, byte 0x02 (save pointer) records byte_count and leaves the phase in message. Byte 0x03 (restore pointer) reloads byte_count from the record and returns the phase to data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_req | input | 8 | One bus request per device ID |
| sel_target | input | 3 | Target ID for a new selection |
| xfer_dir | input | 1 | Direction of a new transfer, 1 = toward the initiator |
| xfer_len | input | 8 | Data bytes in a new transfer |
| byte_in | input | 8 | Byte offered with any strobe |
| cmd_valid | input | 1 | Command byte strobe |
| data_valid | input | 1 | Data byte strobe |
| msg_req | input | 1 | Target asks for the message phase |
| status_valid | input | 1 | Status byte strobe |
| msg_valid | input | 1 | Message byte strobe |
| phase | output | 3 | Current phase code |
| owner_id | output | 3 | Initiator of the live connection |
| target_id | output | 3 | Target of the live connection |
| data_in | output | 1 | Live transfer direction |
| byte_count | output | 8 | Data bytes moved so far |
| bus_byte | output | 8 | Last byte accepted on the bus |
| resume_pending | output | 1 | A disconnected connection is parked |

## Verification
Two of this block's functions can fall in the same data cycle: counting a data byte and leaving for the message phase. The bench drives data_valid and msg_req together. It does this at a random point in the middle of the transfer, and again on the final byte. It then checks that the count went up by one and that the next phase is message for a middle byte and status for the final byte. A second overlap happens in arbitration. Here random request masks, some of which include the parked target alongside lower IDs, are compared against a bench function that picks the highest set bit, and that function's result also decides whether the reselection path is expected.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    typedef enum logic [2:0] {
        PH_FREE  = 3'd0,
        PH_ARB   = 3'd1,
        PH_SEL   = 3'd2,
        PH_RESEL = 3'd3,
        PH_CMD   = 3'd4,
        PH_DATA  = 3'd5,
        PH_STAT  = 3'd6,
        PH_MSG   = 3'd7
    } sbp_phase_e;

    localparam logic [7:0] MSG_DONE  = 8'h00;
    localparam logic [7:0] MSG_SAVEP = 8'h02;
    localparam logic [7:0] MSG_RESTP = 8'h03;
    localparam logic [7:0] MSG_DISC  = 8'h04;

endpackage

// File: rtl/sbp_arbiter.sv
module sbp_arbiter #(
    parameter int N_DEV      = 8,
    parameter int ARB_CYCLES = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     active,
    input  logic [N_DEV-1:0]         req,
    output logic                     done,
    output logic                     win_valid,
    output logic [$clog2(N_DEV)-1:0] win_id
);
    localparam int IDW = $clog2(N_DEV);
    localparam int CW  = $clog2(ARB_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active)
            cnt_d = '0;
        else if (cnt_q != CW'(ARB_CYCLES - 1))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = active && (cnt_q == CW'(ARB_CYCLES - 1));

    // higher index overwrites lower: highest requester wins
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        for (int i = 0; i < N_DEV; i++) begin
            if (req[i]) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
            end
        end
    end

    AST_ARB_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        done && win_valid |-> (req >> win_id) == N_DEV'(1)); // R3

    AST_ARB_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        active && !$past(active) |-> !done || ARB_CYCLES == 1); // R3

endmodule

// File: rtl/sbp_msg_decode.sv
module sbp_msg_decode (
    input  logic [7:0] code,
    output logic       is_done,
    output logic       is_disc,
    output logic       is_save,
    output logic       is_rest,
    output logic       is_ident
);
    import sbp_pkg::*;

    always_comb begin
        is_ident = code[7];
        is_done  = !code[7] && (code == MSG_DONE);
        is_disc  = !code[7] && (code == MSG_DISC);
        is_save  = !code[7] && (code == MSG_SAVEP);
        is_rest  = !code[7] && (code == MSG_RESTP);
    end

endmodule

// File: rtl/sbp_phase_seq.sv
module sbp_phase_seq #(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter int CMD_LEN    = 6,
    parameter int ARB_CYCLES = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [DATA_W-1:0]         arb_req,
    input  logic [$clog2(DATA_W)-1:0] sel_target,
    input  logic                      xfer_dir,
    input  logic [CNT_W-1:0]          xfer_len,
    input  logic [DATA_W-1:0]         byte_in,
    input  logic                      cmd_valid,
    input  logic                      data_valid,
    input  logic                      msg_req,
    input  logic                      status_valid,
    input  logic                      msg_valid,
    output logic [2:0]                phase,
    output logic [$clog2(DATA_W)-1:0] owner_id,
    output logic [$clog2(DATA_W)-1:0] target_id,
    output logic                      data_in,
    output logic [CNT_W-1:0]          byte_count,
    output logic [DATA_W-1:0]         bus_byte,
    output logic                      resume_pending
);
    import sbp_pkg::*;

    localparam int IDW = $clog2(DATA_W);
    localparam int CCW = $clog2(CMD_LEN + 1);

    typedef struct packed {
        sbp_phase_e        ph;
        logic [IDW-1:0]    init;
        logic [IDW-1:0]    tgt;
        logic              dir;
        logic [CNT_W-1:0]  len;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  ptr;
        logic [CCW-1:0]    ccnt;
        logic [DATA_W-1:0] bbyte;
        logic              pend;
        logic [IDW-1:0]    sv_init;
        logic [IDW-1:0]    sv_tgt;
        logic              sv_dir;
        logic [CNT_W-1:0]  sv_len;
        logic [CNT_W-1:0]  sv_ptr;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic           arb_done, win_valid;
    logic [IDW-1:0] win_id;
    logic           m_done, m_disc, m_save, m_rest, m_ident;
    logic [CNT_W-1:0] cnt_inc;

    sbp_arbiter #(
        .N_DEV      (DATA_W),
        .ARB_CYCLES (ARB_CYCLES)
    ) arb_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (st_q.ph == PH_ARB),
        .req       (arb_req),
        .done      (arb_done),
        .win_valid (win_valid),
        .win_id    (win_id)
    );

    sbp_msg_decode dec_i (
        .code     (byte_in),
        .is_done  (m_done),
        .is_disc  (m_disc),
        .is_save  (m_save),
        .is_rest  (m_rest),
        .is_ident (m_ident)
    );

    assign cnt_inc = st_q.cnt + 1'b1;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_FREE: begin
                if (|arb_req) st_d.ph = PH_ARB;
            end
            PH_ARB: begin
                if (arb_done) begin
                    if (!win_valid) begin
                        st_d.ph = PH_FREE;
                    end else if (st_q.pend && win_id == st_q.sv_tgt) begin
                        st_d.ph   = PH_RESEL;
                        st_d.init = st_q.sv_init;
                        st_d.tgt  = win_id;
                    end else begin
                        st_d.ph   = PH_SEL;
                        st_d.init = win_id;
                        st_d.tgt  = sel_target;
                        st_d.dir  = xfer_dir;
                        st_d.len  = xfer_len;
                        st_d.cnt  = '0;
                        st_d.ptr  = '0;
                        st_d.ccnt = '0;
                    end
                end
            end
            PH_SEL: begin
                st_d.ph = PH_CMD;
            end
            PH_RESEL: begin
                st_d.ph   = PH_DATA;
                st_d.dir  = st_q.sv_dir;
                st_d.len  = st_q.sv_len;
                st_d.cnt  = st_q.sv_ptr;
                st_d.ptr  = st_q.sv_ptr;
                st_d.pend = 1'b0;
            end
            PH_CMD: begin
                if (cmd_valid) begin
                    st_d.bbyte = byte_in;
                    if (st_q.ccnt == CCW'(CMD_LEN - 1)) begin
                        st_d.ph   = PH_DATA;
                        st_d.ccnt = '0;
                    end else begin
                        st_d.ccnt = st_q.ccnt + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (st_q.cnt == st_q.len) begin
                    st_d.ph = PH_STAT;
                end else if (data_valid) begin
                    st_d.bbyte = byte_in;
                    st_d.cnt   = cnt_inc;
                    if (cnt_inc == st_q.len) st_d.ph = PH_STAT;
                    else if (msg_req)        st_d.ph = PH_MSG;
                end else if (msg_req) begin
                    st_d.ph = PH_MSG;
                end
            end
            PH_STAT: begin
                if (status_valid) begin
                    st_d.bbyte = byte_in;
                    st_d.ph    = PH_MSG;
                end
            end
            PH_MSG: begin
                if (msg_valid) begin
                    st_d.bbyte = byte_in;
                    if (m_done) begin
                        st_d.ph = PH_FREE;
                    end else if (m_disc) begin
                        st_d.ph      = PH_FREE;
                        st_d.pend    = 1'b1;
                        st_d.sv_init = st_q.init;
                        st_d.sv_tgt  = st_q.tgt;
                        st_d.sv_dir  = st_q.dir;
                        st_d.sv_len  = st_q.len;
                        st_d.sv_ptr  = st_q.cnt;
                    end else if (m_save) begin
                        st_d.ptr = st_q.cnt;
                    end else if (m_rest) begin
                        st_d.cnt = st_q.ptr;
                        st_d.ph  = PH_DATA;
                    end
                end
            end
            default: st_d.ph = PH_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase          = st_q.ph;
    assign owner_id       = st_q.init;
    assign target_id      = st_q.tgt;
    assign data_in        = st_q.dir;
    assign byte_count     = st_q.cnt;
    assign bus_byte       = st_q.bbyte;
    assign resume_pending = st_q.pend;

    AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd0 && arb_req == '0 |=> phase == 3'd0); // R2

    AST_SEL_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd2 |=> phase == 3'd4); // R4

    AST_DATA_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd5 && data_valid && byte_count != st_q.len
        |=> byte_count == $past(byte_count) + 1'b1); // R6

    AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd7 && msg_valid && byte_in == 8'h00 |=> phase == 3'd0); // R9

    AST_DISC_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd7 && msg_valid && byte_in == 8'h04
        |=> phase == 3'd0 && resume_pending); // R10

    AST_RESEL_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 3'd3 |=> phase == 3'd5 && !resume_pending); // R11

endmodule

// File: tb/sbp_phase_seq_tb.sv
module sbp_phase_seq_tb_top;
    localparam int CMD_LEN = 6;
    localparam int ARB_CYCLES = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] arb_req = '0;
    logic [2:0] sel_target = '0;
    logic       xfer_dir = 1'b0;
    logic [7:0] xfer_len = '0;
    logic [7:0] byte_in = '0;
    logic       cmd_valid = 1'b0, data_valid = 1'b0, msg_req = 1'b0;
    logic       status_valid = 1'b0, msg_valid = 1'b0;
    logic [2:0] phase, owner_id, target_id;
    logic       data_in, resume_pending;
    logic [7:0] byte_count, bus_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit       pend = 1'b0;
    int       p_tgt, p_init, p_len, p_cnt;
    bit       p_dir;

    sbp_phase_seq #(.CMD_LEN(CMD_LEN), .ARB_CYCLES(ARB_CYCLES)) dut_i (
        .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .sel_target(sel_target),
        .xfer_dir(xfer_dir), .xfer_len(xfer_len), .byte_in(byte_in),
        .cmd_valid(cmd_valid), .data_valid(data_valid), .msg_req(msg_req),
        .status_valid(status_valid), .msg_valid(msg_valid), .phase(phase),
        .owner_id(owner_id), .target_id(target_id), .data_in(data_in),
        .byte_count(byte_count), .bus_byte(bus_byte),
        .resume_pending(resume_pending)
    );

    always #5 clk = ~clk;

    function automatic int top_bit(logic [7:0] m);
        int w = -1;
        for (int i = 0; i < 8; i++) if (m[i]) w = i;
        return w;
    endfunction

    task automatic chk(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cmd_valid = 0; data_valid = 0; msg_req = 0;
        status_valid = 0; msg_valid = 0; arb_req = '0;
    endtask

    task automatic send_msg(logic [7:0] code);
        byte_in = code; msg_valid = 1; step(); msg_valid = 0;
    endtask

    // arbitration, returns with phase just past the window
    task automatic arbitrate(logic [7:0] mask);
        arb_req = mask; step();
        chk("R2", phase, 1);
        for (int i = 0; i < ARB_CYCLES - 1; i++) step();
        chk("R3", phase, 1);
        step();
        arb_req = '0;
    endtask

    task automatic open_normal(logic [7:0] mask, int tgt, int len, bit dir);
        int w = top_bit(mask);
        sel_target = 3'(tgt); xfer_len = 8'(len); xfer_dir = dir;
        arbitrate(mask);
        chk("R4", phase, 2);
        chk("R4", owner_id, w);
        chk("R4", target_id, tgt);
        step();
        chk("R4", phase, 4);
        for (int i = 0; i < CMD_LEN; i++) begin
            if ($urandom % 3 == 0) begin
                data_valid = 1; step(); data_valid = 0;
                chk("R5", phase, 4);
            end
            byte_in = 8'($urandom); cmd_valid = 1; step(); cmd_valid = 0;
        end
        chk("R5", phase, 5);
        chk("R5", byte_count, 0);
        chk("R5", bus_byte, byte_in);
        chk("R4", data_in, dir);
    endtask

    // moves data from cnt; disc_at < 0 means run to the end
    task automatic run_data(int init, int tgt, int len, bit dir, int cnt, int disc_at);
        if (len == 0) begin
            step(); chk("R6", phase, 6);
        end
        while (cnt < len) begin
            if ($urandom % 4 == 0) begin
                step(); chk("R6", byte_count, cnt);
            end
            byte_in = 8'($urandom); data_valid = 1;
            if (cnt == disc_at || cnt + 1 == len) msg_req = ($urandom % 2 == 0) || cnt == disc_at;
            step(); data_valid = 0; msg_req = 0; cnt++;
            chk("R6", byte_count, cnt);
            if (cnt - 1 == disc_at) begin
                chk("R7", phase, 7);
                send_msg(8'h80 | 8'($urandom % 128));
                chk("R9", phase, 7); chk("R9", byte_count, cnt);
                send_msg(8'h04);
                chk("R10", phase, 0); chk("R10", resume_pending, 1);
                pend = 1; p_tgt = tgt; p_init = init; p_len = len; p_cnt = cnt; p_dir = dir;
                return;
            end
            chk(cnt == len ? "R7" : "R6", phase, cnt == len ? 6 : 5);
        end
        byte_in = 8'($urandom); status_valid = 1; step(); status_valid = 0;
        chk("R8", phase, 7); chk("R8", bus_byte, byte_in);
        send_msg(8'h00);
        chk("R9", phase, 0);
    endtask

    task automatic random_txn();
        logic [7:0] mask;
        int w, tgt, len, disc_at;
        bit dir;
        if (pend && $urandom % 2 == 0)
            mask = (8'd1 << p_tgt) | (8'($urandom) & ((8'd1 << p_tgt) - 1));
        else begin
            mask = 8'($urandom);
            if (mask == 0) mask = 8'h01;
        end
        w = top_bit(mask);
        tgt = $urandom % 8; len = $urandom % 9; dir = 1'($urandom);
        if (pend && w == p_tgt) begin
            sel_target = 3'(tgt);
            arbitrate(mask);
            chk("R11", phase, 3); chk("R11", owner_id, p_init);
            step();
            chk("R11", phase, 5); chk("R11", byte_count, p_cnt);
            chk("R11", resume_pending, 0); chk("R11", data_in, p_dir);
            pend = 0;
            disc_at = (p_len - p_cnt >= 2 && $urandom % 2) ? p_cnt + $urandom % (p_len - p_cnt - 1) : -1;
            run_data(p_init, p_tgt, p_len, p_dir, p_cnt, disc_at);
        end else begin
            open_normal(mask, tgt, len, dir);
            disc_at = (len >= 2 && $urandom % 2) ? $urandom % (len - 1) : -1;
            run_data(w, tgt, len, dir, 0, disc_at);
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk("R1", phase, 0); chk("R1", byte_count, 0); chk("R1", resume_pending, 0);
        rst_n = 1;
        repeat (3) step();
        chk("R2", phase, 0);

        // request vanishes before the window closes
        arb_req = 8'h10; step(); arb_req = '0;
        chk("R2", phase, 1);
        for (int i = 0; i < ARB_CYCLES - 1; i++) step();
        chk("R3", phase, 1);
        step(); chk("R3", phase, 0);

        // equal-time requesters: top ID wins
        open_normal(8'b1010_0110, 2, 0, 1'b0);
        run_data(7, 2, 0, 1'b0, 0, -1);

        // pointer save/restore
        open_normal(8'h08, 5, 6, 1'b1);
        for (int i = 0; i < 2; i++) begin data_valid = 1; step(); end
        data_valid = 0; msg_req = 1; step(); msg_req = 0;
        chk("R7", phase, 7);
        send_msg(8'h02); chk("R12", phase, 7); chk("R12", byte_count, 2);
        send_msg(8'h03); chk("R12", phase, 5); chk("R12", byte_count, 2);
        data_valid = 1; step(); data_valid = 0; chk("R6", byte_count, 3);
        msg_req = 1; step(); msg_req = 0;
        send_msg(8'h03); chk("R12", phase, 5); chk("R12", byte_count, 2);
        run_data(3, 5, 6, 1'b1, 2, -1);

        for (int n = 0; n < 60; n++) random_txn();

        idle_inputs();
        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule